// File: doc/BRIEF.md
# Scheduled-Port Stream Processing Node

This block is one self-timed node of a process-network pipeline. It owns two small input queues, one output queue, an iteration controller, a single-cycle execute stage and the sequencing around them. Each firing takes one operand from one of the two input queues, transforms it, and pushes the result into the output queue. There is no global schedule. The node advances only when its own queue handshakes allow it.

The input queue for each firing is picked by a selection table indexed by a nested iteration domain. The outer index has `OUTER_N` values (4 by default) and the inner index has `INNER_N` values (64 by default), so one run is 256 firings. The table is derived from `PRE_BLOCKS` (2 by default). Outer blocks below that count read the pre-processed port (port 1). The remaining outer blocks read the direct port (port 0).

Reads block on an empty selected queue, and writes block on a full output queue. When the last iteration finishes, the node raises `done` and stays idle until a restart pulse arrives.

Top module: `sn_stream_node`

## Requirements
- R1: After reset, `done` is 0, `res_valid` is 0, and both `src_ready` and `pre_ready` are 1.
- R2: Every firing runs in three ordered phases: get one operand, execute, then put one result. Each result equals the operand plus `OFFSET` (default 16'h0011), modulo 2^16.
- R3: Within a run, firings 0 to 127 take their operands from the pre port (port 1) and firings 128 to 255 take them from the src port (port 0). Outer blocks 0 and 1 select port 1. Each port is consumed in the order it was written.
- R4: While the selected port's queue is empty, the node stalls. Data waiting on the other port is not consumed, and no result is produced.
- R5: While the output queue is full, the pending result and the loop indices are held. No result is dropped or duplicated.
- R6: After the 256th result is queued, `done` is 1. From then on, input data is not consumed and no further result appears.
- R7: A one-cycle `restart` pulse while `done` is 1 clears `done` and starts a new run at the first iteration, which reads port 1.
- R8: A `restart` pulse while `done` is 0 has no effect on the firing sequence.
- R9: Each queue holds `FIFO_DEPTH` entries (default 4). A port's ready output drops to 0 once it holds that many unread entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Starts a new run when `done` is 1 |
| src_wr | input | 1 | Write strobe of the direct input port (port 0) |
| src_data | input | DATA_W | Data of the direct input port |
| src_ready | output | 1 | Direct input queue is not full |
| pre_wr | input | 1 | Write strobe of the pre-processed input port (port 1) |
| pre_data | input | DATA_W | Data of the pre-processed input port |
| pre_ready | output | 1 | Pre-processed input queue is not full |
| res_rd | input | 1 | Read strobe of the result queue |
| res_data | output | DATA_W | Head entry of the result queue |
| res_valid | output | 1 | Result queue is not empty |
| done | output | 1 | The run is complete |

## Verification
The bench first fills the direct port while the node waits on the empty pre-processed port. A node that polled or selected the wrong port would drain that queue, emit results early, or leave `src_ready` high.

Long read stalls on the result queue test the write blocking. A design that advanced its indices while blocked would skip or repeat an operand, and the per-port ordering checks would catch it.

Values written after `done`, and a restart pulse in the middle of a run, target the idle and restart logic. A node that consumed input while idle would lose a value that the second run expects. A node that honoured an early restart would switch ports at the wrong firing.

// File: rtl/sn_pkg.sv
package sn_pkg;
   typedef enum logic [1:0] {
      PH_GET  = 2'd0,
      PH_EXEC = 2'd1,
      PH_PUT  = 2'd2,
      PH_IDLE = 2'd3
   } phase_t;

   localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/sn_fifo.sv
module sn_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sn_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("sn_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) begin
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
         end
         if (do_pop) begin
            rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
         end
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wptr] <= din;
      end
   end
endmodule

// File: rtl/sn_loop_ctrl.sv
module sn_loop_ctrl #(
   parameter int unsigned OUTER_N    = 4,
   parameter int unsigned INNER_N    = 64,
   parameter int unsigned PRE_BLOCKS = 2,
   localparam int unsigned KW = (OUTER_N > 1) ? $clog2(OUTER_N) : 1,
   localparam int unsigned JW = (INNER_N > 1) ? $clog2(INNER_N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          clear,
   output logic [KW-1:0] k_idx,
   output logic [JW-1:0] j_idx,
   output logic          sel_port,
   output logic          last
);
   localparam logic [KW-1:0] K_MAX = KW'(OUTER_N - 1);
   localparam logic [JW-1:0] J_MAX = JW'(INNER_N - 1);

   if (OUTER_N < 2 || INNER_N < 2) begin : g_bad_dom
      $error("sn_loop_ctrl: both loop extents must be at least 2");
   end
   if (PRE_BLOCKS > OUTER_N) begin : g_bad_pre
      $error("sn_loop_ctrl: PRE_BLOCKS exceeds OUTER_N");
   end

   // One table entry per outer block: 1 selects the pre-processed port
   logic [OUTER_N-1:0] sel_tab;
   for (genvar g = 0; g < OUTER_N; g++) begin : g_tab
      assign sel_tab[g] = (g < PRE_BLOCKS);
   end

   assign sel_port = sel_tab[k_idx];
   assign last     = (k_idx == K_MAX) && (j_idx == J_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         k_idx <= '0;
         j_idx <= '0;
      end else if (step) begin
         if (j_idx == J_MAX) begin
            j_idx <= '0;
            k_idx <= (k_idx == K_MAX) ? '0 : k_idx + 1'b1;
         end else begin
            j_idx <= j_idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sn_fire_core.sv
module sn_fire_core
   import sn_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter logic [DATA_W-1:0] OFFSET = DATA_W'(17)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic                 sel_port,
   input  logic                 last,
   input  logic [NUM_PORTS-1:0] in_empty,
   input  logic [DATA_W-1:0]    in_data0,
   input  logic [DATA_W-1:0]    in_data1,
   output logic [NUM_PORTS-1:0] in_pop,
   input  logic                 out_full,
   output logic                 out_push,
   output logic [DATA_W-1:0]    out_data,
   output logic                 step,
   output logic                 clear,
   output logic                 done,
   output phase_t               phase
);
   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] result;
   logic [DATA_W-1:0] sel_data;
   logic              sel_ok;

   assign sel_data = sel_port ? in_data1 : in_data0;
   assign sel_ok   = !in_empty[sel_port];

   always_comb begin
      in_pop = '0;
      if (phase == PH_GET && sel_ok) begin
         in_pop[sel_port] = 1'b1;
      end
   end

   assign out_push = (phase == PH_PUT) && !out_full;
   assign out_data = result;
   assign step     = out_push;
   assign clear    = (phase == PH_IDLE) && restart;
   assign done     = (phase == PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_GET;
         operand <= '0;
         result  <= '0;
      end else begin
         case (phase)
            PH_GET: begin
               if (sel_ok) begin
                  operand <= sel_data;
                  phase   <= PH_EXEC;
               end
            end
            PH_EXEC: begin
               result <= operand + OFFSET;
               phase  <= PH_PUT;
            end
            PH_PUT: begin
               if (!out_full) begin
                  phase <= last ? PH_IDLE : PH_GET;
               end
            end
            default: begin
               if (restart) begin
                  phase <= PH_GET;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sn_stream_node.sv
module sn_stream_node
   import sn_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned OUTER_N    = 4,
   parameter int unsigned INNER_N    = 64,
   parameter int unsigned PRE_BLOCKS = 2,
   parameter logic [DATA_W-1:0] OFFSET = DATA_W'(17)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              src_wr,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   input  logic              pre_wr,
   input  logic [DATA_W-1:0] pre_data,
   output logic              pre_ready,
   input  logic              res_rd,
   output logic [DATA_W-1:0] res_data,
   output logic              res_valid,
   output logic              done
);
   localparam int unsigned KW = (OUTER_N > 1) ? $clog2(OUTER_N) : 1;
   localparam int unsigned JW = (INNER_N > 1) ? $clog2(INNER_N) : 1;

   logic [NUM_PORTS-1:0] in_wr;
   logic [DATA_W-1:0]    in_din  [NUM_PORTS];
   logic [DATA_W-1:0]    in_dout [NUM_PORTS];
   logic [NUM_PORTS-1:0] in_full;
   logic [NUM_PORTS-1:0] in_empty;
   logic [NUM_PORTS-1:0] in_pop;

   logic              out_push, out_full, out_empty;
   logic [DATA_W-1:0] out_din;
   logic              step, clear, sel_port, last;
   logic [KW-1:0]     k_idx;
   logic [JW-1:0]     j_idx;
   phase_t            phase;

   assign in_wr[0]  = src_wr;
   assign in_din[0] = src_data;
   assign in_wr[1]  = pre_wr;
   assign in_din[1] = pre_data;
   assign src_ready = !in_full[0];
   assign pre_ready = !in_full[1];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_in
      sn_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) q_i (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (in_wr[p]),
         .din   (in_din[p]),
         .pop   (in_pop[p]),
         .dout  (in_dout[p]),
         .full  (in_full[p]),
         .empty (in_empty[p])
      );
   end

   sn_loop_ctrl #(
      .OUTER_N(OUTER_N), .INNER_N(INNER_N), .PRE_BLOCKS(PRE_BLOCKS)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .clear    (clear),
      .k_idx    (k_idx),
      .j_idx    (j_idx),
      .sel_port (sel_port),
      .last     (last)
   );

   sn_fire_core #(.DATA_W(DATA_W), .OFFSET(OFFSET)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .sel_port (sel_port),
      .last     (last),
      .in_empty (in_empty),
      .in_data0 (in_dout[0]),
      .in_data1 (in_dout[1]),
      .in_pop   (in_pop),
      .out_full (out_full),
      .out_push (out_push),
      .out_data (out_din),
      .step     (step),
      .clear    (clear),
      .done     (done),
      .phase    (phase)
   );

   sn_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) out_q_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (out_push),
      .din   (out_din),
      .pop   (res_rd),
      .dout  (res_data),
      .full  (out_full),
      .empty (out_empty)
   );

   assign res_valid = !out_empty;
endmodule

// File: rtl/sn_stream_node_chk.sv
module sn_stream_node_chk
   import sn_pkg::*;
#(
   parameter int unsigned KW = 2,
   parameter int unsigned JW = 6,
   parameter int unsigned PRE_BLOCKS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 restart,
   input phase_t               phase,
   input logic [NUM_PORTS-1:0] in_pop,
   input logic [NUM_PORTS-1:0] in_empty,
   input logic                 out_push,
   input logic                 out_full,
   input logic [KW-1:0]        k_idx,
   input logic [JW-1:0]        j_idx,
   input logic                 done
);
   a_r2_one_operand: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_pop));

   a_r2_exec_then_put: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC) |=> (phase == PH_PUT));

   a_r3_pre_port_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      in_pop[1] |-> (k_idx < KW'(PRE_BLOCKS)));

   a_r3_src_port_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      in_pop[0] |-> (k_idx >= KW'(PRE_BLOCKS)));

   a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ((in_pop & in_empty) == '0));

   a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      out_push |-> !out_full);

   a_r5_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PUT && out_full) |=>
         ($stable(k_idx) && $stable(j_idx) && phase == PH_PUT));

   a_r6_idle_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (in_pop == '0 && !out_push));

   a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (done && restart) |=> (!done && k_idx == '0 && j_idx == '0));
endmodule

bind sn_stream_node sn_stream_node_chk #(
   .KW(KW), .JW(JW), .PRE_BLOCKS(PRE_BLOCKS)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .restart  (restart),
   .phase    (phase),
   .in_pop   (in_pop),
   .in_empty (in_empty),
   .out_push (out_push),
   .out_full (out_full),
   .k_idx    (k_idx),
   .j_idx    (j_idx),
   .done     (done)
);

// File: tb/sn_stream_node_tb_top.sv
module sn_stream_node_tb_top;
   localparam int DW    = 16;
   localparam int RUN   = 256;
   localparam int HALF  = 128;
   localparam logic [DW-1:0] OFS = 16'h0011;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          restart = 1'b0;
   logic          src_wr = 1'b0, pre_wr = 1'b0, res_rd = 1'b0;
   logic [DW-1:0] src_data = '0, pre_data = '0;
   logic          src_ready, pre_ready, res_valid, done;
   logic [DW-1:0] res_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [DW-1:0] vals [2][300];
   int wr_idx [2];
   int rd_idx [2];
   int out_n;

   sn_stream_node dut_i (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .src_wr(src_wr), .src_data(src_data), .src_ready(src_ready),
      .pre_wr(pre_wr), .pre_data(pre_data), .pre_ready(pre_ready),
      .res_rd(res_rd), .res_data(res_data), .res_valid(res_valid),
      .done(done)
   );

   always #5 clk = ~clk;

   function automatic int port_of(input int n);
      return (n < HALF) ? 1 : 0;
   endfunction

   function automatic logic [DW-1:0] expect_of(input logic [DW-1:0] d);
      return d + OFS;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_port(input int p, input int upto, input int gap);
      while (wr_idx[p] < upto) begin
         @(negedge clk);
         if (p == 0) src_wr = 1'b0; else pre_wr = 1'b0;
         if (((p == 0) ? src_ready : pre_ready) && ($urandom % 100) >= gap) begin
            if (p == 0) begin src_data = vals[0][wr_idx[0]]; src_wr = 1'b1; end
            else        begin pre_data = vals[1][wr_idx[1]]; pre_wr = 1'b1; end
            wr_idx[p]++;
         end
      end
      @(negedge clk);
      if (p == 0) src_wr = 1'b0; else pre_wr = 1'b0;
   endtask

   task automatic drain(input int count, input int stall);
      int got = 0;
      while (got < count) begin
         @(negedge clk);
         res_rd = 1'b0;
         if (res_valid && ($urandom % 100) >= stall) begin
            int p = port_of(out_n);
            logic [DW-1:0] e = expect_of(vals[p][rd_idx[p]]);
            // R2 value, R3 port order, R5 no drop or duplicate
            check(res_data == e, (p == 1) ? "R3/R2 pre" : "R3/R2 src", res_data, e);
            rd_idx[p]++;
            out_n++;
            got++;
            res_rd = 1'b1;
         end
      end
      @(negedge clk);
      res_rd = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int p = 0; p < 2; p++)
         for (int i = 0; i < 300; i++)
            vals[p][i] = DW'($urandom);
      vals[1][0] = 16'hFFF0;   // wraps on the add
      wr_idx = '{0, 0};
      rd_idx = '{0, 0};
      out_n = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(done == 1'b0, "R1 done", done, 0);
      check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
      check(src_ready && pre_ready, "R1 ready", {src_ready, pre_ready}, 3);

      // R4, R9: src queue fills while the node waits on the empty pre port
      push_port(0, 4, 0);
      repeat (20) @(negedge clk);
      check(src_ready == 1'b0, "R9 src full", src_ready, 0);
      check(res_valid == 1'b0, "R4 stalled", res_valid, 0);

      // Run 1 with slow consumer, R5 long output stalls, R8 early restart
      fork
         push_port(1, HALF, 40);
         push_port(0, HALF, 30);
         begin
            repeat (60) @(negedge clk);
            check(res_valid == 1'b1, "R5 output held", res_valid, 1);
            drain(RUN, 60);
         end
         begin
            repeat (150) @(negedge clk);
            restart = 1'b1;           // R8 ignored mid-run
            @(negedge clk);
            restart = 1'b0;
         end
      join
      repeat (5) @(negedge clk);
      check(done == 1'b1, "R6 done set", done, 1);
      check(res_valid == 1'b0, "R6 no extra output", res_valid, 0);

      // R6: writes while idle must not be consumed
      push_port(0, HALF + 1, 0);
      push_port(1, HALF + 1, 0);
      repeat (30) @(negedge clk);
      check(res_valid == 1'b0, "R6 idle no output", res_valid, 0);
      check(done == 1'b1, "R6 still done", done, 1);

      // R7 restart from idle
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      check(done == 1'b0, "R7 done cleared", done, 0);
      out_n = 0;
      fork
         push_port(1, RUN, 10);
         push_port(0, RUN, 10);
         drain(RUN, 5);
      join
      repeat (5) @(negedge clk);
      check(done == 1'b1, "R7 second run done", done, 1);
      check(rd_idx[0] == RUN && rd_idx[1] == RUN, "R3 counts", rd_idx[0], RUN);

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule